// File: doc/BRIEF.md
# Inter-message deadline watchdog

This block guards a message-driven loader session against stalls. An unlock pulse opens the session and arms a long deadline. Every accepted command message re-arms that deadline. While a streaming data burst is in progress, each data message re-arms a much shorter deadline instead. The message that ends the burst returns the block to the long deadline. Time is measured in ticks of an external microsecond strobe.

If the deadline runs out before the next re-arm, the block emits a one-cycle timeout pulse and drops the session-active flag. Only a new unlock pulse can raise the flag again. Message parsing, memory writes and checksum handling are done by neighbouring logic, which feeds this block with single-cycle event pulses.

Top module: `msg_deadline_wdog`

## Requirements
- R1: While reset is asserted, and directly after it is released, `active_o` and `timeout_o` are both 0 and the counter does not run.
- R2: An `unlock_i` pulse sets `active_o` on the next clock edge and arms the long deadline of `LONG_TICKS` ticks (default 10000). If nothing else happens, `timeout_o` rises on the edge that samples the `LONG_TICKS`-th tick after the unlock.
- R3: While the session is active, a `msg_i` pulse re-arms the full long deadline.
- R4: While the session is active, a `data_i` pulse (a data message inside a burst) arms the short deadline of `SHORT_TICKS` ticks (default 850).
- R5: While the session is active, a `burst_done_i` pulse (the final data message of a burst) arms the long deadline. In any one cycle the priority is `burst_done_i` (long), then `data_i` (short), then `msg_i` (long).
- R6: On expiry, `timeout_o` is high for exactly one cycle and `active_o` falls on the same edge. No further timeout occurs, and `active_o` stays 0, until the next `unlock_i`.
- R7: While the session is inactive, `msg_i`, `data_i`, `burst_done_i` and `tick_i` have no effect: `active_o` stays 0 and `timeout_o` stays 0.
- R8: If a re-arm arrives in the same cycle as the tick that would expire the deadline, the re-arm wins. No timeout occurs, and the new deadline starts from its full value.
- R9: The deadline advances only on cycles where `tick_i` is high. Without ticks, an active session never times out.
- R10: An `unlock_i` pulse during an active session re-arms the long deadline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-microsecond time-base strobe |
| unlock_i | input | 1 | Session-unlock pulse |
| msg_i | input | 1 | Accepted command message pulse |
| data_i | input | 1 | Accepted data-burst message pulse |
| burst_done_i | input | 1 | Final data message of a burst pulse |
| timeout_o | output | 1 | One-cycle deadline-expiry pulse |
| active_o | output | 1 | Session-active flag |

## Verification
Both outputs are registered. An event or tick driven after a falling edge is captured on the next rising edge, and its effect shows on the outputs from that edge onward. The bench therefore drives each cycle's inputs just after a falling edge and compares the outputs at the following falling edge, against a model that is advanced by exactly one cycle per step. Deadline lengths are checked by counting the tick cycles from a re-arm to the first sample that shows `timeout_o` high. For a deadline of N ticks, that must happen on the N-th step.

// File: rtl/msg_wdog_pkg.sv
package msg_wdog_pkg;
  typedef enum logic [1:0] {
    LOAD_NONE  = 2'd0,
    LOAD_LONG  = 2'd1,
    LOAD_SHORT = 2'd2
  } load_e;
endpackage

// File: rtl/wdog_load_sel.sv
module wdog_load_sel
  import msg_wdog_pkg::*;
(
  input  logic  active_i,
  input  logic  unlock_i,
  input  logic  msg_i,
  input  logic  data_i,
  input  logic  burst_done_i,
  output load_e load_o
);
  always_comb begin
    load_o = LOAD_NONE;
    if (unlock_i)               load_o = LOAD_LONG;
    else if (active_i) begin
      if (burst_done_i)         load_o = LOAD_LONG;   // last burst message reverts
      else if (data_i)          load_o = LOAD_SHORT;
      else if (msg_i)           load_o = LOAD_LONG;
    end
  end
endmodule

// File: rtl/wdog_down_cnt.sv
module wdog_down_cnt
  import msg_wdog_pkg::*;
#(
  parameter int unsigned LONG_TICKS  = 10000,
  parameter int unsigned SHORT_TICKS = 850,
  localparam int unsigned CW = $clog2(LONG_TICKS + 1)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  logic  tick_i,
  input  load_e load_i,
  output logic  expire_o
);
  localparam logic [CW-1:0] LongVal  = CW'(LONG_TICKS);
  localparam logic [CW-1:0] ShortVal = CW'(SHORT_TICKS);
  localparam logic [CW-1:0] OneVal   = CW'(1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (load_i == LOAD_NONE) && (cnt_q == OneVal);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case (load_i)
        LOAD_LONG:  cnt_q <= LongVal;
        LOAD_SHORT: cnt_q <= ShortVal;
        default: if (run_i && tick_i && cnt_q != '0) cnt_q <= cnt_q - OneVal;
      endcase
    end
  end

  assert_short_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i == LOAD_SHORT) |=> (cnt_q == ShortVal));
  assert_hold_without_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && load_i == LOAD_NONE) |=> $stable(cnt_q));
  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LongVal);
endmodule

// File: rtl/wdog_session.sv
module wdog_session (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic unlock_i,
  input  logic expire_i,
  output logic active_o,
  output logic timeout_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o  <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      timeout_o <= expire_i;
      if (unlock_i)      active_o <= 1'b1;
      else if (expire_i) active_o <= 1'b0;
    end
  end

  assert_timeout_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
  assert_timeout_drops_active_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !active_o);
endmodule

// File: rtl/msg_deadline_wdog.sv
module msg_deadline_wdog
  import msg_wdog_pkg::*;
#(
  parameter int unsigned LONG_TICKS  = 10000,
  parameter int unsigned SHORT_TICKS = 850
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic unlock_i,
  input  logic msg_i,
  input  logic data_i,
  input  logic burst_done_i,
  output logic timeout_o,
  output logic active_o
);
  load_e load;
  logic  expire;

  wdog_load_sel u_sel (
    .active_i     (active_o),
    .unlock_i     (unlock_i),
    .msg_i        (msg_i),
    .data_i       (data_i),
    .burst_done_i (burst_done_i),
    .load_o       (load)
  );

  wdog_down_cnt #(
    .LONG_TICKS  (LONG_TICKS),
    .SHORT_TICKS (SHORT_TICKS)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (active_o),
    .tick_i   (tick_i),
    .load_i   (load),
    .expire_o (expire)
  );

  wdog_session u_sess (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .unlock_i  (unlock_i),
    .expire_i  (expire),
    .active_o  (active_o),
    .timeout_o (timeout_o)
  );

  assert_unlock_arms_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_i |=> (active_o && !timeout_o));
  assert_reload_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && tick_i && msg_i) |=> !timeout_o);
  assert_idle_ignores_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !unlock_i) |=> (!active_o && !timeout_o));
endmodule

// File: tb/msg_deadline_wdog_test.sv
module msg_deadline_wdog_test;
  localparam int LONG  = 60;
  localparam int SHORT = 12;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 0, unlock_i = 0, msg_i = 0, data_i = 0, burst_done_i = 0;
  logic timeout_o, active_o;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  bit m_active = 0, m_to = 0;
  int m_rem = 0;

  always #2 clk_i = ~clk_i;

  msg_deadline_wdog #(.LONG_TICKS(LONG), .SHORT_TICKS(SHORT)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .unlock_i(unlock_i),
    .msg_i(msg_i), .data_i(data_i), .burst_done_i(burst_done_i),
    .timeout_o(timeout_o), .active_o(active_o));

  // Reference: next-state of the session from the requirements
  function automatic int reload_val(bit u, bit m, bit d, bit b, bit act);
    if (u) return LONG;
    if (!act) return 0;
    if (b) return LONG;
    if (d) return SHORT;
    if (m) return LONG;
    return 0;
  endfunction

  task automatic model(bit u, bit m, bit d, bit b, bit t);
    int rv = reload_val(u, m, d, b, m_active);
    m_to = 0;
    if (rv != 0) begin
      m_rem = rv;
      if (u) m_active = 1;
    end else if (m_active && t) begin
      if (m_rem == 1) begin m_active = 0; m_to = 1; m_rem = 0; end
      else m_rem--;
    end
  endtask

  task automatic check(string req, bit act, bit exp_act, bit to, bit exp_to);
    checks++;
    if (act !== exp_act || to !== exp_to) begin
      errors++;
      $display("FAIL %s: active=%0b exp %0b timeout=%0b exp %0b", req, act, exp_act, to, exp_to);
    end
  endtask

  task automatic step(bit u, bit m, bit d, bit b, bit t);
    unlock_i = u; msg_i = m; data_i = d; burst_done_i = b; tick_i = t;
    model(u, m, d, b, t);
    @(negedge clk_i);
    check(cur_req, active_o, m_active, timeout_o, m_to);
  endtask

  task automatic ticks_to_timeout(string req, int expected);
    int n = 0;
    while (timeout_o !== 1'b1 && n < 4 * LONG) begin
      step(0, 0, 0, 0, 1);
      n++;
    end
    checks++;
    if (n != expected) begin
      errors++;
      $display("FAIL %s: ticks to timeout=%0d exp %0d", req, n, expected);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    check("R1", active_o, 0, timeout_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", active_o, 0, timeout_o, 0);

    cur_req = "R7";
    for (int i = 0; i < 80; i++) step(0, i % 3 == 0, i % 5 == 0, i % 7 == 0, 1);

    cur_req = "R2";
    step(1, 0, 0, 0, 0);
    ticks_to_timeout("R2", LONG);
    cur_req = "R6";
    for (int i = 0; i < LONG + 5; i++) step(0, 0, 0, 0, 1);

    cur_req = "R3";
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 1);
    step(0, 1, 0, 0, 0);
    ticks_to_timeout("R3", LONG);

    cur_req = "R4";
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    ticks_to_timeout("R4", SHORT);

    cur_req = "R5";
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 1, 0, 0);
      for (int k = 0; k < SHORT - 1; k++) step(0, 0, 0, 0, 1);
    end
    step(0, 1, 1, 1, 0);
    ticks_to_timeout("R5", LONG);

    cur_req = "R8";
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < LONG - 1; i++) step(0, 0, 0, 0, 1);
    step(0, 1, 0, 0, 1);
    check("R8", active_o, 1, timeout_o, 0);
    ticks_to_timeout("R8", LONG);

    cur_req = "R9";
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 3 * LONG; i++) step(0, 0, 0, 0, 0);
    check("R9", active_o, 1, timeout_o, 0);

    cur_req = "R10";
    for (int i = 0; i < 50; i++) step(0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0);
    ticks_to_timeout("R10", LONG);

    cur_req = "R5";
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 999));
      step(r < 10, r >= 10 && r < 40, ($urandom_range(0, 99) < 8),
           ($urandom_range(0, 99) < 2), ($urandom_range(0, 99) < 70));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule